// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a single-channel SPI master for one serial link. Software reaches it through three 16-bit registers: a data register, a control register and a status register. Writing a word to the data register while the block is enabled and idle starts one transfer. The block shifts the word out on MOSI, most significant bit first, and samples MISO on the opposite clock edges. When the last bit has been sampled, it latches the received word and sets a receive-full flag. Software then clears the flag by reading the data register.

The control register selects the word size (8 or 16 bits), the clock idle level, which edge launches data and which edge samples it, and a 7-bit SCLK divider. A level interrupt is raised for a waiting received word or for an idle, enabled engine ready to accept a word. Each interrupt source has its own enable. Chip select is driven elsewhere. There is no buffering beyond the single received word.

Top module: `spi_host_ctl`

## Requirements
- R1: Registers sit at fixed offsets: data at 0x0, control at 0x2, status at 0x4.
  - Control fields: bit 0 enable, bit 2 word size (1 = 16-bit), bit 5 receive-full interrupt enable, bit 6 ready interrupt enable, bit 7 late-phase select, bit 8 idle-high select, bits 15:9 divider.
  - The other control bits read back as 0. Writing 0xFFFF reads back as 0xFFE5.
  - Status reads bit 0 busy and bit 1 receive-full; all other status bits read 0.
- R2: A data write while enabled and not busy starts a transfer. Busy reads 1 for exactly 2·N·(D+1) clock cycles, where N is 8 or 16 bits and D is the effective divider.
- R3: Each SCLK half-period lasts D+1 clock cycles, where D is the divider field. A field of 0 is treated as 1, so the SCLK division ratio spans 4 (field 1) to 256 (field 127).
- R4: Bits are shifted MSB first.
  - In 16-bit mode the whole word is sent and received.
  - In 8-bit mode only bits 7:0 are sent, and the received word has bits 15:8 equal to 0.
- R5: The idle-high bit sets the idle SCLK level, which SCLK shows whenever no transfer runs.
  - With the late-phase bit clear, MISO is sampled on the first edge of each bit and MOSI changes on the second edge.
  - With the late-phase bit set, MOSI changes on the first edge and MISO is sampled on the second.
- R6: Receive-full is set when a transfer completes. It is cleared by a read of the data register.
- R7: A data write is ignored while busy or while the block is disabled. The word in flight is unaffected, and no transfer starts.
- R8: Clearing the enable bit during a transfer stops it within one cycle. SCLK returns to idle and receive-full is not set.
- R9: irq = (receive-full AND receive interrupt enable) OR (NOT busy AND enable AND ready interrupt enable).
- R10: Reset clears all registers and flags, holds SCLK low and drives MOSI low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read (valid with reg_sel) |
| reg_addr | input | 3 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| spi_miso | input | 1 | Serial data from the slave |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume one register access per cycle. They also assume that software does not clear the enable bit in the same cycle as a transfer's final edge, so a completion and an abort never coincide. The stimulus keeps to this by issuing every access as a single-cycle strobe and aborting only deep inside a slow transfer. A slave model in the bench changes MISO only on its own launch edges, which always lie at least two clock cycles before the master's sampling edge. This keeps MISO stable where the design samples it.

// File: rtl/spi_host_pkg.sv
`timescale 1ns/1ps
package spi_host_pkg;

    localparam int REG_AW = 3;
    localparam int DW     = 16;
    localparam int DIV_W  = 7;
    localparam int HALF   = DW / 2;

    localparam logic [REG_AW-1:0] ADDR_DATA = 3'h0;
    localparam logic [REG_AW-1:0] ADDR_CTL  = 3'h2;
    localparam logic [REG_AW-1:0] ADDR_STAT = 3'h4;

    // control word, field order fixed by the register map
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             idle_hi;
        logic             phase_late;
        logic             ie_rdy;
        logic             ie_rx;
        logic [1:0]       rsv_hi;
        logic             wide;
        logic             rsv_lo;
        logic             en;
    } ctl_t;

    // settings frozen for the duration of one word
    typedef struct packed {
        logic             wide;
        logic             phase_late;
        logic             idle_hi;
        logic [DIV_W-1:0] div;
    } xfer_cfg_t;

    typedef enum logic {ST_IDLE, ST_SHIFT} eng_state_e;

    function automatic ctl_t ctl_clean(input logic [DW-1:0] w);
        ctl_t c;
        c        = ctl_t'(w);
        c.rsv_hi = '0;
        c.rsv_lo = 1'b0;
        return c;
    endfunction

    function automatic logic [DIV_W-1:0] div_eff(input logic [DIV_W-1:0] d);
        return (d == '0) ? DIV_W'(1) : d;
    endfunction

    function automatic int word_edges(input logic wide);
        return wide ? 2 * DW : DW;
    endfunction

endpackage

// File: rtl/spi_host_regs.sv
`timescale 1ns/1ps
module spi_host_regs
    import spi_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              busy,
    input  logic              rbf,
    input  logic [DW-1:0]     rx_word,
    output ctl_t              ctl,
    output logic              start,
    output logic [DW-1:0]     tx_word,
    output logic              data_rd,
    output logic [DW-1:0]     rdata
);
    logic wr_ctl, wr_data;

    assign wr_ctl  = sel & wr & (addr == ADDR_CTL);
    assign wr_data = sel & wr & (addr == ADDR_DATA);
    assign data_rd = sel & ~wr & (addr == ADDR_DATA);
    assign start   = wr_data & ctl.en & ~busy;
    assign tx_word = wdata;

    always_ff @(posedge clk) begin
        if (rst)         ctl <= '0;
        else if (wr_ctl) ctl <= ctl_clean(wdata);
    end

    always_comb begin
        case (addr)
            ADDR_DATA: rdata = rx_word;
            ADDR_CTL:  rdata = ctl;
            ADDR_STAT: rdata = {{(DW-2){1'b0}}, rbf, busy};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_host_clkgen.sv
`timescale 1ns/1ps
module spi_host_clkgen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] start_div,
    input  logic             run,
    input  logic [DIV_W-1:0] run_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // one tick every run_div+1 cycles while a word is in flight
    assign tick = run & (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (start) cnt <= start_div;
        else if (run) begin
            if (cnt == '0) cnt <= run_div;
            else           cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/spi_host_shifter.sv
`timescale 1ns/1ps
module spi_host_shifter
    import spi_host_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          en,
    input  logic [DW-1:0] tx_word,
    input  xfer_cfg_t     cfg_in,
    input  logic          tick,
    input  logic          miso,
    output logic          busy,
    output logic          done,
    output xfer_cfg_t     cfg,
    output logic          sclk_q,
    output logic          mosi,
    output logic [DW-1:0] rx_word
);
    localparam int CW = $clog2(2 * DW + 1);

    eng_state_e    state;
    logic [DW-1:0] txs, rxs, rx_next, tx_aligned;
    logic [CW-1:0] ecnt;
    logic          sample_now, last;

    always_comb begin
        // edge number is ecnt+1; odd edges lead, even edges trail
        sample_now = (~ecnt[0]) ^ cfg.phase_late;
        last       = (ecnt + CW'(1)) == CW'(word_edges(cfg.wide));
        rx_next    = sample_now ? {rxs[DW-2:0], miso} : rxs;
        tx_aligned = cfg_in.wide ? tx_word : {tx_word[HALF-1:0], {HALF{1'b0}}};
    end

    assign busy = (state == ST_SHIFT);
    assign done = busy & en & tick & last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg     <= '0;
            txs     <= '0;
            rxs     <= '0;
            ecnt    <= '0;
            sclk_q  <= 1'b0;
            mosi    <= 1'b0;
            rx_word <= '0;
        end else if (start) begin
            state  <= ST_SHIFT;
            cfg    <= cfg_in;
            ecnt   <= '0;
            rxs    <= '0;
            sclk_q <= cfg_in.idle_hi;
            if (!cfg_in.phase_late) begin
                mosi <= tx_aligned[DW-1];
                txs  <= tx_aligned << 1;
            end else begin
                txs  <= tx_aligned;
            end
        end else if (busy) begin
            if (!en) begin
                state  <= ST_IDLE;
                sclk_q <= cfg.idle_hi;
            end else if (tick) begin
                sclk_q <= ~sclk_q;
                ecnt   <= ecnt + 1'b1;
                if (sample_now) begin
                    rxs <= rx_next;
                end else if (!last) begin
                    mosi <= txs[DW-1];
                    txs  <= txs << 1;
                end
                if (last) begin
                    state   <= ST_IDLE;
                    rx_word <= cfg.wide ? rx_next : {{HALF{1'b0}}, rx_next[HALF-1:0]};
                end
            end
        end
    end
endmodule

// File: rtl/spi_host_ctl.sv
`timescale 1ns/1ps
module spi_host_ctl
    import spi_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              spi_miso,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              irq
);
    ctl_t          ctl_q;
    xfer_cfg_t     cfg_new, cfg_cur;
    logic          start, data_rd, busy, done, tick, rbf, sclk_q;
    logic [DW-1:0] tx_word, rx_word;

    always_comb begin
        cfg_new.wide       = ctl_q.wide;
        cfg_new.phase_late = ctl_q.phase_late;
        cfg_new.idle_hi    = ctl_q.idle_hi;
        cfg_new.div        = div_eff(ctl_q.div);
    end

    spi_host_regs u_regs (
        .clk(clk), .rst(rst), .sel(reg_sel), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .busy(busy), .rbf(rbf), .rx_word(rx_word),
        .ctl(ctl_q), .start(start), .tx_word(tx_word), .data_rd(data_rd),
        .rdata(reg_rdata)
    );

    spi_host_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst(rst), .start(start), .start_div(cfg_new.div),
        .run(busy), .run_div(cfg_cur.div), .tick(tick)
    );

    spi_host_shifter u_shift (
        .clk(clk), .rst(rst), .start(start), .en(ctl_q.en), .tx_word(tx_word),
        .cfg_in(cfg_new), .tick(tick), .miso(spi_miso), .busy(busy),
        .done(done), .cfg(cfg_cur), .sclk_q(sclk_q), .mosi(spi_mosi),
        .rx_word(rx_word)
    );

    // completion wins over a read in the same cycle
    always_ff @(posedge clk) begin
        if (rst)          rbf <= 1'b0;
        else if (done)    rbf <= 1'b1;
        else if (data_rd) rbf <= 1'b0;
    end

    assign spi_sclk = busy ? sclk_q : ctl_q.idle_hi;
    assign irq      = (rbf & ctl_q.ie_rx) | (~busy & ctl_q.en & ctl_q.ie_rdy);
endmodule

// File: rtl/spi_host_ctl_chk.sv
`timescale 1ns/1ps
module spi_host_ctl_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic data_rd,
    input logic data_wr,
    input logic rbf,
    input logic en,
    input logic idle_hi,
    input logic sclk,
    input logic irq
);
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && en && data_wr && !done) |=> busy);

    assert_abort_stops_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> !busy);

    assert_flag_on_done_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> rbf);

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !done) |=> !rbf);

    assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == idle_hi));

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!rbf && !en) |-> !irq);
endmodule

bind spi_host_ctl spi_host_ctl_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .data_rd(data_rd), .data_wr(reg_sel & reg_wr & (reg_addr == 3'd0)),
    .rbf(rbf), .en(ctl_q.en), .idle_hi(ctl_q.idle_hi), .sclk(spi_sclk),
    .irq(irq)
);

// File: tb/spi_host_ctl_tb.sv
`timescale 1ns/1ps
module spi_host_ctl_tb;

    typedef struct packed {
        logic        idle;
        logic        phase;
        logic        wide;
        logic [6:0]  div;
        logic [15:0] tx;
        logic [15:0] sw;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 7'd1,   16'h00A5, 16'h003C},
        '{1'b0, 1'b1, 1'b0, 7'd127, 16'h0081, 16'h007E},
        '{1'b1, 1'b0, 1'b0, 7'd1,   16'h00C3, 16'h0096},
        '{1'b1, 1'b1, 1'b0, 7'd0,   16'h005A, 16'h00F0},
        '{1'b0, 1'b0, 1'b1, 7'd127, 16'hBEEF, 16'h1234},
        '{1'b0, 1'b1, 1'b1, 7'd1,   16'h8001, 16'hCAFE},
        '{1'b1, 1'b0, 1'b1, 7'd1,   16'h1357, 16'hFFFF},
        '{1'b1, 1'b1, 1'b1, 7'd127, 16'hF00D, 16'h0001}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0, wr = 1'b0;
    logic [2:0]  addr = 3'h4;
    logic [15:0] wdata = '0;
    logic        miso = 1'b0;
    logic [15:0] rdata;
    logic        sclk, mosi, irq;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // slave model state
    logic        s_on = 1'b0, s_idle = 1'b0, s_ph = 1'b0;
    logic [15:0] s_word = '0, s_cap = '0;
    int          s_idx = 0;

    always #4 clk = ~clk;

    spi_host_ctl u_dut (
        .clk(clk), .rst(rst), .reg_sel(sel), .reg_wr(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .spi_miso(miso),
        .spi_sclk(sclk), .spi_mosi(mosi), .irq(irq)
    );

    always @(sclk) begin
        if (s_on) begin
            if ((sclk != s_idle) ^ s_ph) begin
                s_cap = {s_cap[14:0], mosi};
            end else if (s_idx >= 0) begin
                miso  = s_word[s_idx];
                s_idx = s_idx - 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; addr = 3'h4;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 v = rdata;
        @(negedge clk);
        addr = 3'h4;
    endtask

    task automatic slave_arm(input logic idle, input logic ph, input logic wide, input logic [15:0] w);
        int n;
        n = wide ? 16 : 8;
        s_idle = idle; s_ph = ph; s_word = w; s_cap = '0;
        if (!ph) begin
            miso  = w[n-1];
            s_idx = n - 2;
        end else begin
            s_idx = n - 1;
        end
        s_on = 1'b1;
    endtask

    // returns number of cycles busy stayed high, starting at the negedge after the write
    task automatic wait_idle(output int cyc);
        cyc = 0;
        forever begin
            #1;
            if (!rdata[0] || cyc > 20000) break;
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int cyc, nb, expc;
        logic [15:0] r, mask;
        nb   = v.wide ? 16 : 8;
        mask = v.wide ? 16'hFFFF : 16'h00FF;
        expc = nb * 2 * (((v.div == 0) ? 1 : int'(v.div)) + 1);
        bus_wr(3'h2, {v.div, v.idle, v.phase, 1'b0, 1'b1, 2'b00, v.wide, 1'b0, 1'b1});
        #1 check("R5 idle sclk", {31'b0, sclk}, {31'b0, v.idle});
        slave_arm(v.idle, v.phase, v.wide, v.sw);
        bus_wr(3'h0, v.tx);
        wait_idle(cyc);
        s_on = 1'b0;
        check("R2 R3 busy length", cyc, expc);
        check("R6 flag set", {31'b0, rdata[1]}, 32'd1);
        check("R9 irq on rx", {31'b0, irq}, 32'd1);
        check("R5 sclk back idle", {31'b0, sclk}, {31'b0, v.idle});
        bus_rd(3'h0, r);
        check("R4 R5 rx word", {16'b0, r}, {16'b0, v.sw & mask});
        check("R4 R5 mosi word", {16'b0, s_cap & mask}, {16'b0, v.tx & mask});
        #1 check("R6 flag cleared", {31'b0, rdata[1]}, 32'd0);
        check("R9 irq drops", {31'b0, irq}, 32'd0);
    endtask

    initial begin
        logic [15:0] r;
        int cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        #1 check("R10 sclk", {31'b0, sclk}, 32'd0);
        check("R10 mosi", {31'b0, mosi}, 32'd0);
        check("R10 irq", {31'b0, irq}, 32'd0);
        bus_rd(3'h4, r);
        check("R10 status", {16'b0, r}, 32'd0);
        bus_rd(3'h2, r);
        check("R10 control", {16'b0, r}, 32'd0);

        // R1 field layout and readback
        bus_wr(3'h2, 16'hFFFF);
        bus_rd(3'h2, r);
        check("R1 control readback", {16'b0, r}, 32'h0000FFE5);
        #1 check("R1 status idle", {16'b0, rdata}, 32'd0);
        check("R5 idle high", {31'b0, sclk}, 32'd1);
        check("R9 ready irq", {31'b0, irq}, 32'd1);

        // R7 data write while disabled
        bus_wr(3'h2, 16'h0000);
        bus_wr(3'h0, 16'h00AA);
        #1 check("R7 disabled no start", {31'b0, rdata[0]}, 32'd0);
        check("R7 disabled mosi quiet", {31'b0, mosi}, 32'd0);

        // vector table
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R7 data write while busy
        bus_wr(3'h2, 16'h0221);
        slave_arm(1'b0, 1'b0, 1'b0, 16'h003C);
        bus_wr(3'h0, 16'h00A6);
        bus_wr(3'h0, 16'h0059);
        wait_idle(cyc);
        s_on = 1'b0;
        bus_rd(3'h0, r);
        check("R7 busy write rx", {16'b0, r}, 32'h0000003C);
        check("R7 busy write mosi", {24'b0, s_cap[7:0]}, 32'h000000A6);

        // R8 abort by clearing enable
        bus_wr(3'h2, 16'hFE65);
        bus_wr(3'h0, 16'h1234);
        repeat (50) @(negedge clk);
        #1 check("R8 still busy", {31'b0, rdata[0]}, 32'd1);
        check("R9 no ready irq while busy", {31'b0, irq}, 32'd0);
        bus_wr(3'h2, 16'hFE64);
        @(negedge clk);
        #1 check("R8 busy dropped", {31'b0, rdata[0]}, 32'd0);
        check("R8 sclk idle", {31'b0, sclk}, 32'd0);
        repeat (10) @(negedge clk);
        #1 check("R8 no flag", {31'b0, rdata[1]}, 32'd0);
        check("R9 irq off when disabled", {31'b0, irq}, 32'd0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule